// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It watches the up and down pulses of a phase-frequency detector with a fast sampling clock. A reference window is the span from one reference edge to the next. In each window the block counts the sampling cycles in which exactly one of the two pulses is high. When that mismatch count is no larger than a selectable tolerance, the window is clean. Once a programmed number of clean windows follow one another, the lock flag is raised.

A mode input sets what happens after lock. In continuous mode every window is still judged, and one dirty window drops the flag. In first-lock mode the flag holds until the loop is restarted. Pulling the enable low clears everything, and the next enable starts a fresh acquisition. Downstream status logic can place the lock flag in a read-only status word.

Top module: `pll_lock_det`

## Requirements
- R1: While rst_ni is low, lock_o and lock_strobe_o are 0.
- R2: The mismatch of a window is the number of sampling cycles, from the cycle that carries a reference edge up to but not including the next such cycle, in which up_i and dn_i differ.
- R3: A window is clean when its mismatch is at most the tolerance. The tolerance is TOL_LO (15) for tol_sel_i=0 and TOL_HI (30) for tol_sel_i=1.
- R4: lock_time_i values 0, 1, 2 and 3 require 2, 4, 8 and 16 consecutive clean windows. The first reference edge after enable only opens a window. lock_o rises in the cycle after the reference edge that closes the last required clean window.
- R5: With latch_mode_i=0, a dirty window closing while locked clears lock_o in the cycle after its closing edge, and the count of clean windows starts again from zero.
- R6: With latch_mode_i=1, once lock_o is set it stays set regardless of mismatch until en_i goes low.
- R7: en_i low clears lock_o and the clean-window count at the next clock edge. After en_i returns high, a full new run of clean windows is needed.
- R8: lock_strobe_o is high for exactly one cycle, the cycle in which lock_o goes from 0 to 1.
- R9: Before lock, in either mode, a dirty window resets the clean-window count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low means the loop is stopped or restarting |
| ref_edge_i | input | 1 | One-cycle pulse marking a reference clock edge |
| up_i | input | 1 | Up pulse of the phase-frequency detector |
| dn_i | input | 1 | Down pulse of the phase-frequency detector |
| lock_time_i | input | 2 | Selects the required clean-window count: 2, 4, 8 or 16 |
| tol_sel_i | input | 1 | Selects the mismatch tolerance: 0 for TOL_LO, 1 for TOL_HI |
| latch_mode_i | input | 1 | 0 for continuous checking, 1 to latch after the first lock |
| lock_o | output | 1 | Lock flag |
| lock_strobe_o | output | 1 | One-cycle pulse when lock is achieved |

## Verification
The bench uses the default tolerances of 15 and 30 sampling cycles and a reference period of 40 sampling cycles. With these values, a pulse skew of up to 31 cycles fits inside one window, so the mismatch can be placed exactly at each tolerance and one cycle past it. The default lengths allow all four lock-time settings. The 16-window case is timed down to the exact reference edge, and dirty windows are placed both before and after lock.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic {
    LD_CONTINUOUS = 1'b0,
    LD_FIRST_LOCK = 1'b1
  } ld_mode_e;

  localparam int unsigned LT_SEL_W = 2;
  localparam int unsigned NEED_MAX = 2 << ((1 << LT_SEL_W) - 1);

  function automatic int unsigned need_windows(input logic [LT_SEL_W-1:0] sel);
    return 2 << sel;
  endfunction
endpackage

// File: rtl/pld_mismatch_meter.sv
module pld_mismatch_meter #(
  parameter int unsigned TOL_LO = 15,
  parameter int unsigned TOL_HI = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ref_edge_i,
  input  logic up_i,
  input  logic dn_i,
  input  logic tol_sel_i,
  output logic win_done_o,
  output logic win_good_o
);
  localparam int unsigned TOL_MAX = (TOL_HI > TOL_LO) ? TOL_HI : TOL_LO;
  localparam int unsigned CNT_W   = $clog2(TOL_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] mm_q;
  logic             seen_q;
  logic             mis;
  logic [CNT_W-1:0] tol;

  assign mis = up_i ^ dn_i;
  assign tol = tol_sel_i ? CNT_W'(TOL_HI) : CNT_W'(TOL_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mm_q   <= '0;
      seen_q <= 1'b0;
    end else if (!en_i) begin
      mm_q   <= '0;
      seen_q <= 1'b0;
    end else if (ref_edge_i) begin
      mm_q   <= CNT_W'(mis);
      seen_q <= 1'b1;
    end else if (mis && mm_q != CNT_SAT) begin
      mm_q <= mm_q + 1'b1;
    end
  end

  // first edge after enable only opens a window
  assign win_done_o = en_i && ref_edge_i && seen_q;
  assign win_good_o = (mm_q <= tol);

  AST_MM_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ref_edge_i && !mis) |=> $stable(mm_q)); // R2
  AST_MM_NEW_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ref_edge_i) |=> (mm_q <= 1)); // R2
endmodule

// File: rtl/pld_lock_tracker.sv
module pld_lock_tracker
  import pld_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                win_done_i,
  input  logic                win_good_i,
  input  logic [LT_SEL_W-1:0] lock_time_i,
  input  logic                latch_mode_i,
  output logic                lock_o,
  output logic                strobe_o
);
  localparam int unsigned RUN_W = $clog2(NEED_MAX + 1);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W:0]   run_nx;
  logic [RUN_W:0]   need;
  logic             lock_q;
  logic             strobe_q;
  logic             hold;

  assign run_nx = {1'b0, run_q} + 1'b1;
  assign need   = (RUN_W+1)'(need_windows(lock_time_i));
  assign hold   = lock_q && (ld_mode_e'(latch_mode_i) == LD_FIRST_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      lock_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else if (!en_i) begin
      run_q    <= '0;
      lock_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (win_done_i && !hold) begin
        if (win_good_i) begin
          if (run_nx >= need) begin
            lock_q   <= 1'b1;
            strobe_q <= !lock_q;
          end
          if (run_q != RUN_W'(NEED_MAX)) run_q <= run_nx[RUN_W-1:0];
        end else begin
          run_q  <= '0;
          lock_q <= 1'b0;
        end
      end
    end
  end

  assign lock_o   = lock_q;
  assign strobe_o = strobe_q;

  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(NEED_MAX)); // R4
  AST_LOCK_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && win_done_i && win_good_i && en_i && run_nx >= need) |=> lock_q); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && latch_mode_i && en_i) |=> lock_q); // R6
  AST_DISABLE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!lock_q && run_q == '0)); // R7
  AST_DIRTY_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && win_done_i && !win_good_i && !hold) |=> (run_q == '0 && !lock_q)); // R5
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det
  import pld_pkg::*;
#(
  parameter int unsigned TOL_LO = 15,
  parameter int unsigned TOL_HI = 30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                ref_edge_i,
  input  logic                up_i,
  input  logic                dn_i,
  input  logic [LT_SEL_W-1:0] lock_time_i,
  input  logic                tol_sel_i,
  input  logic                latch_mode_i,
  output logic                lock_o,
  output logic                lock_strobe_o
);
  logic win_done;
  logic win_good;

  pld_mismatch_meter #(.TOL_LO(TOL_LO), .TOL_HI(TOL_HI)) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .ref_edge_i (ref_edge_i),
    .up_i       (up_i),
    .dn_i       (dn_i),
    .tol_sel_i  (tol_sel_i),
    .win_done_o (win_done),
    .win_good_o (win_good)
  );

  pld_lock_tracker u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .win_done_i   (win_done),
    .win_good_i   (win_good),
    .lock_time_i  (lock_time_i),
    .latch_mode_i (latch_mode_i),
    .lock_o       (lock_o),
    .strobe_o     (lock_strobe_o)
  );

  AST_STROBE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_strobe_o |-> (lock_o && !$past(lock_o))); // R8
  AST_RISE_HAS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> lock_strobe_o); // R8
  AST_RISE_AFTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(ref_edge_i)); // R4
endmodule

// File: tb/pll_lock_det_test.sv
module pll_lock_det_test;
  localparam int CLK_PERIOD = 10;
  localparam int REF_P      = 40;
  localparam int PW         = 5;
  localparam int NVEC       = 8;

  typedef struct packed {
    logic [1:0] lt;
    logic       tol;
    logic [5:0] skew;
    logic [4:0] exp_call; // 0 = never locks
  } vec_t;

  // expected first call sampling lock = need + 1
  localparam vec_t VECS [NVEC] = '{
    '{lt: 2'd3, tol: 1'b0, skew: 6'd0,  exp_call: 5'd17},
    '{lt: 2'd0, tol: 1'b0, skew: 6'd0,  exp_call: 5'd3},
    '{lt: 2'd1, tol: 1'b0, skew: 6'd15, exp_call: 5'd5},
    '{lt: 2'd2, tol: 1'b0, skew: 6'd16, exp_call: 5'd0},
    '{lt: 2'd2, tol: 1'b1, skew: 6'd30, exp_call: 5'd9},
    '{lt: 2'd0, tol: 1'b1, skew: 6'd31, exp_call: 5'd0},
    '{lt: 2'd3, tol: 1'b1, skew: 6'd16, exp_call: 5'd17},
    '{lt: 2'd1, tol: 1'b0, skew: 6'd7,  exp_call: 5'd5}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       ref_edge = 1'b0;
  logic       up = 1'b0;
  logic       dn = 1'b0;
  logic [1:0] lt = 2'd0;
  logic       tol = 1'b0;
  logic       mode = 1'b0;
  logic       lock;
  logic       strobe;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  bit done = 1'b0;

  pll_lock_det uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ref_edge_i(ref_edge),
    .up_i(up), .dn_i(dn), .lock_time_i(lt), .tol_sel_i(tol),
    .latch_mode_i(mode), .lock_o(lock), .lock_strobe_o(strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (strobe) strobes++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one reference window; lk/st sampled one cycle after its opening edge
  task automatic window(input int skew, output logic lk, output logic st);
    @(negedge clk);
    ref_edge = 1'b1; up = 1'b0; dn = 1'b0;
    for (int c = 1; c < REF_P; c++) begin
      @(negedge clk);
      if (c == 1) begin lk = lock; st = strobe; end
      ref_edge = 1'b0;
      up = (c < 1 + PW + skew);
      dn = (c < 1 + PW);
    end
  endtask

  task automatic restart(input logic [1:0] l, input logic t, input logic m);
    @(negedge clk);
    en = 1'b0; lt = l; tol = t; mode = m;
    repeat (2) @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic lk, st;
    int first, s0;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(lock == 1'b0, "R1 lock in reset", int'(lock), 0);
    check(strobe == 1'b0, "R1 strobe in reset", int'(strobe), 0);
    rst_n = 1'b1;

    // table: R2 R3 R4 R8
    for (int v = 0; v < NVEC; v++) begin
      restart(VECS[v].lt, VECS[v].tol, 1'b0);
      s0 = strobes;
      first = 0;
      for (int k = 1; k <= 20; k++) begin
        window(int'(VECS[v].skew), lk, st);
        if (lk && first == 0) first = k;
      end
      check(first == int'(VECS[v].exp_call), "R3/R4 first lock window", first, int'(VECS[v].exp_call));
      check(strobes - s0 == (VECS[v].exp_call != 0 ? 1 : 0), "R8 strobe count",
            strobes - s0, (VECS[v].exp_call != 0 ? 1 : 0));
    end

    // R5 continuous drop and relock
    restart(2'd0, 1'b0, 1'b0);
    window(0, lk, st); window(0, lk, st); window(0, lk, st);
    check(lk == 1'b1, "R5 locked before drop", int'(lk), 1);
    check(st == 1'b1, "R8 strobe with lock rise", int'(st), 1);
    window(20, lk, st);
    window(0, lk, st);
    check(lk == 1'b0, "R5 dirty window clears lock", int'(lk), 0);
    window(0, lk, st);
    check(lk == 1'b0, "R5 recount after drop", int'(lk), 0);
    window(0, lk, st);
    check(lk == 1'b1, "R5 relock after two clean", int'(lk), 1);

    // R6 first-lock hold, then R7 disable
    restart(2'd0, 1'b0, 1'b1);
    window(0, lk, st); window(0, lk, st); window(31, lk, st);
    check(lk == 1'b1, "R6 latched lock", int'(lk), 1);
    s0 = 0;
    for (int k = 0; k < 4; k++) begin
      window(31, lk, st);
      if (!lk) s0++;
    end
    check(s0 == 0, "R6 hold through dirty windows", s0, 0);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check(lock == 1'b0, "R7 enable low clears lock", int'(lock), 0);
    @(negedge clk); en = 1'b1;
    window(0, lk, st); window(0, lk, st);
    check(lk == 1'b0, "R7 fresh count after enable", int'(lk), 0);
    window(0, lk, st);
    check(lk == 1'b1, "R7 relock after full run", int'(lk), 1);

    // R9 dirty window before lock resets count (need 4)
    restart(2'd1, 1'b0, 1'b1);
    first = 0;
    for (int k = 1; k <= 10; k++) begin
      window((k == 3) ? 20 : 0, lk, st);
      if (lk && first == 0) first = k;
    end
    check(first == 8, "R9 lock delayed by dirty window", first, 8);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule